// File: doc/BRIEF.md
# Partitioned SIMD Compare-to-Mask Unit

This unit takes two 64-bit operands and compares them lane by lane. The lanes are either four 16-bit lanes or two 32-bit lanes. It packs the outcome of each lane into one bit of a small mask. The mask is zero-extended to 64 bits and goes out on an integer-register result path. It is never written back into a vector register.

A 9-bit operation code picks the lane width and the condition. The condition is one of greater-than, equal, less-or-equal or not-equal. Each comparison is evaluated as first-source lane OP second-source lane.

The control is a three-state machine:
- `ST_IDLE`: no result is being presented.
- `ST_DONE`: a legal operation was accepted on the previous clock.
- `ST_BAD`: an unknown opcode was presented on the previous clock.

The machine moves on every clock:
- A strobe with a legal opcode goes to `ST_DONE`.
- A strobe with an unknown opcode goes to `ST_BAD`.
- No strobe returns it to `ST_IDLE`.

This applies from any state. The result register loads on every strobe and holds otherwise.

Top module: `simd_cmp_mask`

## Requirements
- R1: With 16-bit lanes, lane i covers operand bits [16i+15:16i], lane 0 being the least significant, and lane i's outcome drives result bit i (i = 0..3).
- R2: With 32-bit lanes, lane i covers operand bits [32i+31:32i] and drives result bit i (i = 0..1); result bits 63..2 are zero.
- R3: With 16-bit lanes, result bits 63..4 are zero.
- R4: Greater-than is true when the first-source lane is larger than the second-source lane, both read as two's-complement signed.
- R5: Less-or-equal is true when the first-source lane is not larger than the second, read as signed.
- R6: Equal is true when the two lanes are bit-identical; not-equal is its complement.
- R7: The opcode map (hex) is:
  - 020 le16, 022 ne16, 024 le32, 026 ne32
  - 028 gt16, 02A eq16, 02C gt32, 02E eq32
- R8: A strobe with any other opcode gives, one clock later, illegal_op high for one cycle, res_valid low and a zero result.
- R9: A strobe with a legal opcode gives res_valid high one clock later with the mask on result. In a cycle with no strobe, res_valid and illegal_op are low the next clock and result holds its value.
- R10: A synchronous active-high reset clears result, res_valid and illegal_op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 9 | Operation code selecting lane width and condition |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| result | output | 64 | Zero-extended lane mask, registered |
| res_valid | output | 1 | Result valid, one clock after a legal strobe |
| illegal_op | output | 1 | One clock after a strobe with an unknown opcode |

## Verification
The bench runs each of the eight opcodes on lanes that are all equal, mixed per lane, and signed extremes (0x8000 against 0x7FFF, all-ones against zero, and all-ones against itself):
- Equal lanes separate the eq/le cases from gt/ne.
- The signed extremes show whether the comparison treats lanes as signed or unsigned.
- Mixed lanes expose a lane-order or bit-position error.

Unknown opcodes, including neighbours with bit 0 set, and idle cycles confirm the zero result, the one-cycle flag and the holding behaviour. Randomized operands over all legal opcodes are compared every clock against a behavioural model.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    typedef enum logic {
        LW_NARROW = 1'b0,
        LW_WIDE   = 1'b1
    } lane_w_e;

    typedef enum logic [1:0] {
        CND_GT = 2'd0,
        CND_EQ = 2'd1,
        CND_LE = 2'd2,
        CND_NE = 2'd3
    } cond_e;

    typedef struct packed {
        logic    legal;
        lane_w_e width;
        cond_e   cond;
    } op_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_BAD  = 2'd2
    } cmp_state_e;

endpackage

// File: rtl/simd_cmp_decode.sv
module simd_cmp_decode
    import simd_cmp_pkg::*;
#(
    parameter int OP_W = 9
) (
    input  logic [OP_W-1:0] opcode,
    output op_dec_t         dec
);

    always_comb begin
        dec = '{legal: 1'b1, width: LW_NARROW, cond: CND_GT};
        unique case (opcode)
            OP_W'(9'h020): begin dec.width = LW_NARROW; dec.cond = CND_LE; end
            OP_W'(9'h022): begin dec.width = LW_NARROW; dec.cond = CND_NE; end
            OP_W'(9'h024): begin dec.width = LW_WIDE;   dec.cond = CND_LE; end
            OP_W'(9'h026): begin dec.width = LW_WIDE;   dec.cond = CND_NE; end
            OP_W'(9'h028): begin dec.width = LW_NARROW; dec.cond = CND_GT; end
            OP_W'(9'h02A): begin dec.width = LW_NARROW; dec.cond = CND_EQ; end
            OP_W'(9'h02C): begin dec.width = LW_WIDE;   dec.cond = CND_GT; end
            OP_W'(9'h02E): begin dec.width = LW_WIDE;   dec.cond = CND_EQ; end
            default:       dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/simd_cmp_lanes.sv
module simd_cmp_lanes #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [LANES-1:0]  gt,
    output logic [LANES-1:0]  eq
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [LANE_W-1:0] la;
        logic signed [LANE_W-1:0] lb;
        assign la    = a[g*LANE_W +: LANE_W];
        assign lb    = b[g*LANE_W +: LANE_W];
        assign gt[g] = la > lb;
        assign eq[g] = la == lb;
    end

endmodule

// File: rtl/simd_cmp_pack.sv
module simd_cmp_pack
    import simd_cmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int N_LANES = 4,
    parameter int W_LANES = 2
) (
    input  lane_w_e           width,
    input  cond_e             cond,
    input  logic [N_LANES-1:0] n_gt,
    input  logic [N_LANES-1:0] n_eq,
    input  logic [W_LANES-1:0] w_gt,
    input  logic [W_LANES-1:0] w_eq,
    output logic [DATA_W-1:0]  mask
);

    logic [N_LANES-1:0] n_sel;
    logic [W_LANES-1:0] w_sel;

    always_comb begin
        unique case (cond)
            CND_GT: begin n_sel = n_gt;  w_sel = w_gt;  end
            CND_EQ: begin n_sel = n_eq;  w_sel = w_eq;  end
            CND_LE: begin n_sel = ~n_gt; w_sel = ~w_gt; end
            CND_NE: begin n_sel = ~n_eq; w_sel = ~w_eq; end
            default: begin n_sel = '0;   w_sel = '0;    end
        endcase
    end

    always_comb begin
        mask = '0;
        if (width == LW_NARROW) mask[N_LANES-1:0] = n_sel;
        else                    mask[W_LANES-1:0] = w_sel;
    end

endmodule

// File: rtl/simd_cmp_mask.sv
module simd_cmp_mask
    import simd_cmp_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int OP_W     = 9,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              res_valid,
    output logic              illegal_op
);

    localparam int N_LANES = DATA_W / NARROW_W;
    localparam int W_LANES = DATA_W / WIDE_W;

    op_dec_t            dec;
    logic [N_LANES-1:0] n_gt, n_eq;
    logic [W_LANES-1:0] w_gt, w_eq;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  result_q;
    cmp_state_e         state_q, state_d;

    simd_cmp_decode #(.OP_W(OP_W)) u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    simd_cmp_lanes #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_narrow (
        .a  (src_a),
        .b  (src_b),
        .gt (n_gt),
        .eq (n_eq)
    );

    simd_cmp_lanes #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_wide (
        .a  (src_a),
        .b  (src_b),
        .gt (w_gt),
        .eq (w_eq)
    );

    simd_cmp_pack #(.DATA_W(DATA_W), .N_LANES(N_LANES), .W_LANES(W_LANES)) u_pack (
        .width (dec.width),
        .cond  (dec.cond),
        .n_gt  (n_gt),
        .n_eq  (n_eq),
        .w_gt  (w_gt),
        .w_eq  (w_eq),
        .mask  (mask)
    );

    always_comb begin
        if (!in_valid)      state_d = ST_IDLE;
        else if (dec.legal) state_d = ST_DONE;
        else                state_d = ST_BAD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) result_q <= dec.legal ? mask : '0;
        end
    end

    always_comb begin
        res_valid  = 1'b0;
        illegal_op = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: res_valid  = 1'b1;
            ST_BAD:  illegal_op = 1'b1;
            default: ;
        endcase
    end

    assign result = result_q;

    // R9
    legal_done_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.legal) |=> (res_valid && !illegal_op));

    // R8
    bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec.legal) |=> (illegal_op && !res_valid && result == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && !illegal_op && $stable(result)));

    // R3
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.legal && dec.width == LW_NARROW) |=> (result[DATA_W-1:N_LANES] == '0));

    // R2
    wide_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.legal && dec.width == LW_WIDE) |=> (result[DATA_W-1:W_LANES] == '0));

endmodule

// File: tb/simd_cmp_mask_tb.sv
`timescale 1ns/1ps
module simd_cmp_mask_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [8:0]  opcode = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] result;
    logic        res_valid;
    logic        illegal_op;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0] exp_res = '0;
    logic        exp_vld = 1'b0;
    logic        exp_ill = 1'b0;

    always #4 clk = ~clk;

    simd_cmp_mask dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b),
        .result(result), .res_valid(res_valid), .illegal_op(illegal_op)
    );

    // Behavioural model: cond 0=gt 1=eq 2=le 3=ne
    function automatic logic [63:0] model(input logic [8:0] op, input logic [63:0] a,
                                          input logic [63:0] b, output bit ok);
        int w, cnd;
        logic [63:0] m;
        ok = 1; w = 16; cnd = 0; m = '0;
        case (op)
            9'h020: begin w = 16; cnd = 2; end
            9'h022: begin w = 16; cnd = 3; end
            9'h024: begin w = 32; cnd = 2; end
            9'h026: begin w = 32; cnd = 3; end
            9'h028: begin w = 16; cnd = 0; end
            9'h02A: begin w = 16; cnd = 1; end
            9'h02C: begin w = 32; cnd = 0; end
            9'h02E: begin w = 32; cnd = 1; end
            default: ok = 0;
        endcase
        if (!ok) return '0;
        for (int i = 0; i < 64 / w; i++) begin
            logic [63:0] ta, tb;
            longint sa, sb;
            bit hit;
            ta = a >> (i * w);
            tb = b >> (i * w);
            if (w == 16) begin
                sa = longint'($signed(ta[15:0]));
                sb = longint'($signed(tb[15:0]));
            end else begin
                sa = longint'($signed(ta[31:0]));
                sb = longint'($signed(tb[31:0]));
            end
            case (cnd)
                0: hit = sa > sb;
                1: hit = sa == sb;
                2: hit = sa <= sb;
                default: hit = sa != sb;
            endcase
            m[i] = hit;
        end
        return m;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (result !== exp_res || res_valid !== exp_vld || illegal_op !== exp_ill) begin
            fails++;
            $display("FAIL %s: result=%h vld=%b ill=%b expected result=%h vld=%b ill=%b",
                     tag, result, res_valid, illegal_op, exp_res, exp_vld, exp_ill);
        end
    endtask

    task automatic apply(input logic v, input logic [8:0] op, input logic [63:0] a,
                         input logic [63:0] b, input string tag);
        bit ok;
        logic [63:0] m;
        in_valid = v; opcode = op; src_a = a; src_b = b;
        m = model(op, a, b, ok);
        if (rst) begin
            exp_res = '0; exp_vld = 0; exp_ill = 0;
        end else begin
            exp_vld = v && ok;
            exp_ill = v && !ok;
            if (v) exp_res = ok ? m : '0;
        end
        @(posedge clk);
        #2;
        compare(tag);
    endtask

    task automatic all_ops(input logic [63:0] a, input logic [63:0] b, input string tag);
        logic [8:0] ops [8] = '{9'h020, 9'h022, 9'h024, 9'h026, 9'h028, 9'h02A, 9'h02C, 9'h02E};
        foreach (ops[k]) apply(1'b1, ops[k], a, b, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        apply(1'b0, 9'h0, '0, '0, "R10 reset");
        apply(1'b1, 9'h028, 64'h1, 64'h0, "R10 reset ignores strobe");
        rst = 1'b0;
        // R1 lane order: only lane 2 greater
        apply(1'b1, 9'h028, 64'h0000_0005_0000_0000, '0, "R1 lane2 gt16");
        apply(1'b1, 9'h02A, 64'h1111_2222_3333_4444, 64'h1111_0000_3333_0000, "R1 eq16 mixed");
        // R2 wide lanes
        apply(1'b1, 9'h02C, 64'h0000_0001_0000_0000, '0, "R2 gt32 upper");
        apply(1'b1, 9'h02E, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0001, "R2 eq32");
        // R3 upper zero with all-ones mask
        apply(1'b1, 9'h022, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R3 ne16 all ones");
        checks++;
        if (result[63:4] !== '0) begin
            fails++;
            $display("FAIL R3: upper=%h expected 0", result[63:4]);
        end
        // R4 / R5 signed extremes
        apply(1'b1, 9'h028, 64'h7FFF_8000_7FFF_8000, 64'h8000_7FFF_8000_7FFF, "R4 gt16 signed");
        apply(1'b1, 9'h02C, 64'h7FFF_FFFF_8000_0000, 64'h8000_0000_7FFF_FFFF, "R4 gt32 signed");
        apply(1'b1, 9'h020, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R5 le16 minus one");
        apply(1'b1, 9'h024, 64'h8000_0000_0000_0005, 64'h7FFF_FFFF_0000_0005, "R5 le32");
        // R6 equal lanes and all-ones against itself
        all_ops(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R6 all ones equal");
        all_ops(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R6 equal lanes");
        all_ops(64'h8000_0001_7FFF_0000, 64'h7FFF_0001_8000_FFFF, "R7 mixed");
        // R8 illegal opcodes
        apply(1'b1, 9'h021, 64'h5, 64'h1, "R8 odd neighbour");
        apply(1'b1, 9'h030, 64'h5, 64'h1, "R8 beyond map");
        apply(1'b1, 9'h1FF, 64'h5, 64'h1, "R8 all ones op");
        apply(1'b0, 9'h021, 64'h5, 64'h1, "R8 flag one cycle");
        // R9 hold on idle
        apply(1'b1, 9'h02A, 64'h0, 64'h0, "R9 load");
        apply(1'b0, 9'h028, 64'h0, 64'h1, "R9 idle hold");
        apply(1'b0, 9'h1FF, 64'h0, 64'h1, "R9 idle illegal op ignored");
        // R7 random over legal map
        for (int n = 0; n < 400; n++) begin
            logic [8:0] op;
            logic [63:0] a, b;
            op = 9'h020 + 9'(2 * $urandom_range(0, 7));
            a = {$urandom, $urandom};
            b = ($urandom_range(0, 3) == 0) ? a ^ (64'h1 << $urandom_range(0, 63)) : {$urandom, $urandom};
            apply($urandom_range(0, 4) != 0, op, a, b, "R7 random");
        end
        // R10 reset mid-stream
        rst = 1'b1;
        apply(1'b1, 9'h022, 64'h1, 64'h2, "R10 reset mid-stream");
        rst = 1'b0;
        apply(1'b0, 9'h0, '0, '0, "R10 after reset");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule